// File: doc/BRIEF.md
# Maximal-Length Shift-Register Sequence Generator

This block steps a WIDTH-bit register through every non-zero value of a maximal-length sequence. It can serve as a counter with very little logic or as a pseudo-random source. The feedback taps come from a primitive polynomial that is passed in as a bit mask. Bit i of the mask is the coefficient of x^i for i from 0 to WIDTH-1, and the leading x^WIDTH term is implied. The taps sit between stages, with one two-input XOR in front of each tapped stage. No XOR feeds another, so the logic depth per cycle stays the same at any width.

A synchronous reset starts the register at the value 1. A seed can be loaded at any time, and a loaded zero is replaced by 1 so the register can never reach the all-zero lock-up state. The loaded value (or 1 after reset) is also kept as the reference point of the cycle. A one-cycle wrap pulse marks each enabled step that brings the register back to that reference value.

Top module: `lfsr_seq_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the next `state` is 1 and `wrap` is 0. The stored reference value becomes 1. `rst` has priority over every other input.
- R2: On an enabled step (`step_en`=1, `seed_load`=0), the feedback bit f is the old `state[WIDTH-1]`. The new `state[0]` is f AND mask bit 0. For 0<i<WIDTH, the new `state[i]` is old `state[i-1]` XOR (f AND mask bit i).
- R3: With WIDTH=4 and mask 4'b0011 (x^4+x+1), starting from 0001, the register steps through 0001, 0010, 0100, 1000, 0011, 0110, 1100, 1011, 0101, 1010, 0111, 1110, 1111, 1101, 1001 and then returns to 0001.
- R4: With a primitive mask, 2^WIDTH−1 enabled steps visit every non-zero state exactly once. For the default WIDTH=8 with mask 8'h1D (x^8+x^4+x^3+x^2+1), that is 255 distinct values.
- R5: With `step_en`=0, `seed_load`=0 and `rst`=0, `state` holds its value and `wrap` is 0 in the next cycle.
- R6: With `seed_load`=1 and a non-zero `seed_value`, the next `state` equals `seed_value` whatever `step_en` is. That value becomes the new reference, and `wrap` is 0.
- R7: With `seed_load`=1 and `seed_value`=0, the next `state` is 1 and the reference becomes 1.
- R8: `wrap` is high for exactly one cycle after each enabled step whose new `state` equals the reference. With a primitive mask this happens every 2^WIDTH−1 enabled steps, counted from a load or reset.
- R9: After reset, `state` is never zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Advance the sequence by one step |
| seed_load | input | 1 | Load `seed_value` as state and reference |
| seed_value | input | WIDTH | Seed to load (zero is replaced by 1) |
| state | output | WIDTH | Current register value |
| wrap | output | 1 | One-cycle pulse when a step returns to the reference |

## Verification
The assertions assume that the mask is primitive and that all inputs hold known values from the first reset onward. The wrap-period check in particular depends on the mask being primitive. The stimulus uses only the two primitive masks named in R3 and R4. It holds reset high from time zero and changes inputs on the falling edge. It checks the loaded seeds (non-zero, zero, and a load that arrives together with an enable) and the hold cycles at the ports in the following cycle.

// File: rtl/lfsr_seq_pkg.sv
package lfsr_seq_pkg;

    // Action selected for the current cycle, highest priority last.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_STEP  = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_RESET = 2'd3
    } lfsr_act_e;

endpackage

// File: rtl/lfsr_ctrl_decode.sv
module lfsr_ctrl_decode
    import lfsr_seq_pkg::*;
(
    input  logic      rst,
    input  logic      step_en,
    input  logic      seed_load,
    output lfsr_act_e act
);

    always_comb begin
        if (rst) begin
            act = ACT_RESET;
        end else if (seed_load) begin
            act = ACT_LOAD;
        end else if (step_en) begin
            act = ACT_STEP;
        end else begin
            act = ACT_HOLD;
        end
    end

endmodule

// File: rtl/lfsr_seed_guard.sv
module lfsr_seed_guard #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] raw_seed,
    output logic [WIDTH-1:0] safe_seed
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    // A zero seed would lock the register; substitute the value 1.
    always_comb begin
        safe_seed = (raw_seed == '0) ? ONE : raw_seed;
    end

endmodule

// File: rtl/lfsr_galois_step.sv
module lfsr_galois_step #(
    parameter int               WIDTH = 8,
    parameter logic [WIDTH-1:0] POLY  = 8'h1D
) (
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] nxt
);

    logic fb;
    assign fb = cur[WIDTH-1];

    // Stage 0 takes the feedback directly when the constant term is present.
    if (POLY[0]) begin : g_x0_tap
        assign nxt[0] = fb;
    end else begin : g_x0_none
        assign nxt[0] = 1'b0;
    end

    // Each higher stage either shifts or takes one two-input XOR.
    for (genvar i = 1; i < WIDTH; i++) begin : g_stage
        if (POLY[i]) begin : g_tap
            assign nxt[i] = cur[i-1] ^ fb;
        end else begin : g_shift
            assign nxt[i] = cur[i-1];
        end
    end

endmodule

// File: rtl/lfsr_seq_gen.sv
module lfsr_seq_gen
    import lfsr_seq_pkg::*;
#(
    parameter int               WIDTH = 8,
    parameter logic [WIDTH-1:0] POLY  = 8'h1D
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_en,
    input  logic             seed_load,
    input  logic [WIDTH-1:0] seed_value,
    output logic [WIDTH-1:0] state,
    output logic             wrap
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    typedef struct packed {
        logic [WIDTH-1:0] lfsr;
        logic [WIDTH-1:0] seed;
        logic             wrap;
    } regs_t;

    regs_t            r_d;
    regs_t            r_q;
    lfsr_act_e        act;
    logic [WIDTH-1:0] step_val;
    logic [WIDTH-1:0] seed_safe;

    lfsr_ctrl_decode i_decode (
        .rst       (rst),
        .step_en   (step_en),
        .seed_load (seed_load),
        .act       (act)
    );

    lfsr_seed_guard #(.WIDTH(WIDTH)) i_guard (
        .raw_seed  (seed_value),
        .safe_seed (seed_safe)
    );

    lfsr_galois_step #(.WIDTH(WIDTH), .POLY(POLY)) i_step (
        .cur (r_q.lfsr),
        .nxt (step_val)
    );

    always_comb begin
        r_d      = r_q;
        r_d.wrap = 1'b0;
        unique case (act)
            ACT_RESET: begin
                r_d.lfsr = ONE;
                r_d.seed = ONE;
            end
            ACT_LOAD: begin
                r_d.lfsr = seed_safe;
                r_d.seed = seed_safe;
            end
            ACT_STEP: begin
                r_d.lfsr = step_val;
                r_d.wrap = (step_val == r_q.seed);
            end
            default: begin
                r_d.lfsr = r_q.lfsr;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign state = r_q.lfsr;
    assign wrap  = r_q.wrap;

endmodule

// File: rtl/lfsr_seq_gen_chk.sv
module lfsr_seq_gen_chk #(
    parameter int               WIDTH = 8,
    parameter logic [WIDTH-1:0] POLY  = 8'h1D
) (
    input logic             clk,
    input logic             rst,
    input logic             step_en,
    input logic             seed_load,
    input logic [WIDTH-1:0] seed_value,
    input logic [WIDTH-1:0] state,
    input logic             wrap,
    input logic [WIDTH-1:0] seed_ref
);

    localparam logic [WIDTH:0] PERIOD = {1'b0, {WIDTH{1'b1}}};

    // Enabled steps since the last reset, load or wrap.
    logic [WIDTH:0] steps_q;
    always_ff @(posedge clk) begin
        if (rst || seed_load) begin
            steps_q <= '0;
        end else begin
            steps_q <= (wrap ? '0 : steps_q) + {{WIDTH{1'b0}}, step_en};
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (state == WIDTH'(1)) && !wrap);

    assert_step_bit0_R2: assert property (@(posedge clk) disable iff (rst)
        (step_en && !seed_load) |=> state[0] == ($past(state[WIDTH-1]) & POLY[0]));

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!step_en && !seed_load) |=> $stable(state) && !wrap);

    assert_load_value_R6: assert property (@(posedge clk) disable iff (rst)
        (seed_load && seed_value != '0) |=> (state == $past(seed_value)) && !wrap);

    assert_zero_seed_R7: assert property (@(posedge clk) disable iff (rst)
        (seed_load && seed_value == '0) |=> state == WIDTH'(1));

    assert_wrap_on_ref_R8: assert property (@(posedge clk) disable iff (rst)
        wrap |-> (state == seed_ref) && $past(step_en && !seed_load));

    assert_wrap_period_R8: assert property (@(posedge clk) disable iff (rst)
        wrap |-> steps_q == PERIOD);

    assert_no_lockup_R9: assert property (@(posedge clk) disable iff (rst)
        state != '0);

endmodule

bind lfsr_seq_gen lfsr_seq_gen_chk #(.WIDTH(WIDTH), .POLY(POLY)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .step_en    (step_en),
    .seed_load  (seed_load),
    .seed_value (seed_value),
    .state      (state),
    .wrap       (wrap),
    .seed_ref   (r_q.seed)
);

// File: tb/test_lfsr_seq_gen.sv
`timescale 1ns/1ps
module test_lfsr_seq_gen;

    localparam logic [7:0] P8 = 8'h1D;
    localparam logic [3:0] P4 = 4'h3;
    localparam logic [3:0] SEQ4 [0:14] = '{4'h1, 4'h2, 4'h4, 4'h8, 4'h3, 4'h6, 4'hC,
                                           4'hB, 4'h5, 4'hA, 4'h7, 4'hE, 4'hF, 4'hD, 4'h9};

    typedef struct {
        logic [7:0] st;
        logic       wr;
        bit         sel4;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en8 = 1'b0, ld8 = 1'b0;
    logic [7:0] sd8 = '0;
    logic [7:0] st8;
    logic       wr8;
    logic       en4 = 1'b0, ld4 = 1'b0;
    logic [3:0] sd4 = '0;
    logic [3:0] st4;
    logic       wr4;

    exp_t       sb[$];
    int         checks = 0;
    int         fails  = 0;
    logic [7:0] m8, ref8;
    int         i4;

    always #2.5 clk = ~clk;

    lfsr_seq_gen #(.WIDTH(8), .POLY(P8)) i_lfsr_seq_gen (
        .clk(clk), .rst(rst), .step_en(en8), .seed_load(ld8),
        .seed_value(sd8), .state(st8), .wrap(wr8)
    );

    lfsr_seq_gen #(.WIDTH(4), .POLY(P4)) i_lfsr_seq_gen_w4 (
        .clk(clk), .rst(rst), .step_en(en4), .seed_load(ld4),
        .seed_value(sd4), .state(st4), .wrap(wr4)
    );

    function automatic logic [7:0] ref_step8(input logic [7:0] s);
        logic [7:0] r;
        r = {s[6:0], 1'b0};
        if (s[7]) r = r ^ P8;
        return r;
    endfunction

    task automatic check_val(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: compare every queued expectation just after the edge.
    always @(posedge clk) begin
        exp_t e;
        logic [7:0] a_st;
        logic       a_wr;
        #1;
        while (sb.size() > 0) begin
            e    = sb.pop_front();
            a_st = e.sel4 ? {4'b0, st4} : st8;
            a_wr = e.sel4 ? wr4 : wr8;
            checks++;
            if (a_st !== e.st || a_wr !== e.wr) begin
                fails++;
                $display("FAIL %s state=%h wrap=%b expected state=%h wrap=%b",
                         e.tag, a_st, a_wr, e.st, e.wr);
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; en8 = 0; ld8 = 0; en4 = 0; ld4 = 0;
        m8 = 8'd1; ref8 = 8'd1; i4 = 0;
        sb.push_back('{8'd1, 1'b0, 1'b0, "R1"});
        sb.push_back('{8'd1, 1'b0, 1'b1, "R1"});
    endtask

    // Driver for the 8-bit unit: updates the reference model and queues the result.
    task automatic step8(input logic en, input logic ld, input logic [7:0] seed,
                         input string tag);
        logic w;
        @(negedge clk);
        rst = 1'b0; en8 = en; ld8 = ld; sd8 = seed; en4 = 0; ld4 = 0;
        w = 1'b0;
        if (ld) begin
            m8   = (seed == 8'd0) ? 8'd1 : seed;
            ref8 = m8;
        end else if (en) begin
            m8 = ref_step8(m8);
            w  = (m8 == ref8);
        end
        sb.push_back('{m8, w, 1'b0, tag});
    endtask

    // Driver for the 4-bit unit: expectations come from the listed sequence.
    task automatic step4(input string tag);
        @(negedge clk);
        rst = 1'b0; en8 = 0; ld8 = 0; en4 = 1; ld4 = 0;
        i4 = (i4 + 1) % 15;
        sb.push_back('{{4'b0, SEQ4[i4]}, (i4 == 0), 1'b1, tag});
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        bit [255:0] seen;
        int         distinct;
        int         wraps;

        // R1 reset state on both units
        do_reset();

        // R3 4-bit listed sequence, wrap after 15 steps (R8)
        for (int k = 0; k < 16; k++) step4("R3");

        // R5 hold on the 8-bit unit
        for (int k = 0; k < 3; k++) step8(1'b0, 1'b0, 8'h00, "R5");

        // R2/R4/R9 full period from 1, collecting distinct values
        seen = '0; distinct = 0; wraps = 0;
        for (int k = 0; k < 255; k++) begin
            step8(1'b1, 1'b0, 8'h00, "R2");
            @(posedge clk); #2;
            if (st8 == 8'd0) check_val("R9", 0, 1);
            if (!seen[st8]) distinct++;
            seen[st8] = 1'b1;
            if (wr8) wraps++;
        end
        check_val("R4 distinct states", distinct, 255);
        check_val("R8 wraps per period", wraps, 1);

        // R6 load wins over enable; then R8 period from a new seed
        step8(1'b1, 1'b1, 8'hA5, "R6");
        wraps = 0;
        for (int k = 0; k < 255; k++) begin
            step8(1'b1, 1'b0, 8'h00, "R8");
            @(posedge clk); #2;
            if (wr8) wraps++;
        end
        check_val("R8 wraps from seed", wraps, 1);
        check_val("R8 back at seed", int'(st8), 8'hA5);

        // R5 hold mid-run, with the wrap pulse cleared
        for (int k = 0; k < 5; k++) step8(1'b1, 1'b0, 8'h00, "R2");
        for (int k = 0; k < 2; k++) step8(1'b0, 1'b0, 8'h3C, "R5");

        // R7 zero seed becomes 1, then a few steps from there
        step8(1'b0, 1'b1, 8'h00, "R7");
        for (int k = 0; k < 4; k++) step8(1'b1, 1'b0, 8'h00, "R7");

        // R1 reset mid-run
        do_reset();
        step8(1'b1, 1'b0, 8'h00, "R1");

        @(negedge clk); en8 = 0; en4 = 0; rst = 0;
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule